// File: doc/BRIEF.md
# Memory-Mapped Configurable GPIO Port Controller

This block controls three groups of pads from a small register bus. A general port and a special port each hold a configuration register and a data register, and each has a read-only location that returns the synchronized pad levels. For every pin, the configuration bit and the data bit are decoded together. A clear configuration bit makes the pin an input, and the data bit then chooses whether the weak pull-up is on. A set configuration bit makes the pin drive the data bit. A third port drives outputs only and has a single data register. That register is preset to all ones while reset is held.

On the special port the two top bits of each register are given other jobs. The two top configuration bits are stored and brought out as a serial-clock phase select and a clock start-up delay enable. A write to the data register with bit 7 or bit 6 set sends a one-cycle halt request or idle request to a power sequencer elsewhere. These two data bits are never stored and always read back as zero. The two top pads of the special port are never driven and never pulled up.

The request side uses a valid/ready handshake. The block always accepts, so `req_ready` is held high. A requester may present a new request on every cycle. A request is taken on each rising edge where `req_valid` is high. A read answer comes back with `rsp_valid` one cycle later. The response side has no back-pressure: the requester must take the answer in the cycle it is offered.

Top module: `gpio_portset`

## Requirements
- R1: While reset is held and just after it is released, every configuration and data bit of the general and special ports is zero. All their pads then have output enable 0 and pull-up 0. `halt_req`, `idle_req`, `sk_alt_phase` and `clk_start_delay` are 0.
- R2: A pin whose configuration bit is 0 and whose data bit is 0 is high-impedance: output enable 0 and pull-up 0.
- R3: A pin whose configuration bit is 0 and whose data bit is 1 is an input with its pull-up on: output enable 0 and pull-up 1.
- R4: A pin whose configuration bit is 1 drives the value of its data bit: output enable 1, output equal to the data bit, pull-up 0. A register changes only when it is written.
- R5: The address map is as follows. General port: configuration at 0x0, data at 0x1, pins at 0x2. Special port: configuration at 0x4, data at 0x5, pins at 0x6. Output-only port: data at 0x8. A read of a configuration or data register returns the value last written, and the answer appears with `rsp_valid` in the cycle after the read is accepted.
- R6: The pin locations return the pad inputs after a two-flop synchronizer. A read accepted on the third rising edge after a pad change returns the new level, and this includes special-port pins 6 and 7.
- R7: Writes to the pin locations and to unmapped addresses change no register. A read of an unmapped address returns 0.
- R8: A write to special data (0x5) with bit 7 set makes `halt_req` high for the one cycle after the write edge. The same write with bit 6 set does the same for `idle_req`. Neither request is held beyond that cycle unless the write is repeated.
- R9: Special data bits 7 and 6 always read as 0. Special pads 7 and 6 always have output enable 0 and pull-up 0.
- R10: Special configuration bit 6 drives `sk_alt_phase` and bit 7 drives `clk_start_delay`. Both are stored and read back at 0x4.
- R11: The output-only data register is set to 0xFF whenever reset is asserted, drives `d_out` directly, and reads back at 0x8.
- R12: `req_ready` is always 1. Every request with `req_valid` high is taken at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read answer valid |
| rsp_rdata | output | 8 | Read answer data |
| a_pad_in | input | 8 | General port pad levels |
| a_pad_oe | output | 8 | General port output enables |
| a_pad_out | output | 8 | General port output values |
| a_pad_pu | output | 8 | General port pull-up enables |
| b_pad_in | input | 8 | Special port pad levels |
| b_pad_oe | output | 8 | Special port output enables |
| b_pad_out | output | 8 | Special port output values |
| b_pad_pu | output | 8 | Special port pull-up enables |
| d_out | output | 8 | Output-only port values |
| halt_req | output | 1 | One-cycle halt request pulse |
| idle_req | output | 1 | One-cycle idle request pulse |
| sk_alt_phase | output | 1 | Alternate serial-clock phase select |
| clk_start_delay | output | 1 | Clock start-up delay enable |

## Verification
Pad controls, `d_out`, the serial-phase select and the start-delay enable are decoded combinationally from registers, so they are due in the cycle right after the write edge. The bench samples them on the falling edge that follows that write. The halt and idle pulses are also due in that cycle, and the bench checks them there and again one cycle later, when they must have dropped. A read answer is due one cycle after acceptance, and a pad change shows up only in a read accepted on the third rising edge after it. The bench waits two full rising edges before issuing any pin read.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  parameter int ADDR_W = 4;
  parameter int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CFG = 4'h0;
  localparam logic [ADDR_W-1:0] A_DAT = 4'h1;
  localparam logic [ADDR_W-1:0] A_PIN = 4'h2;
  localparam logic [ADDR_W-1:0] B_CFG = 4'h4;
  localparam logic [ADDR_W-1:0] B_DAT = 4'h5;
  localparam logic [ADDR_W-1:0] B_PIN = 4'h6;
  localparam logic [ADDR_W-1:0] D_DAT = 4'h8;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_A_CFG, SEL_A_DAT, SEL_A_PIN,
    SEL_B_CFG, SEL_B_DAT, SEL_B_PIN, SEL_D_DAT
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W       = 8,
  parameter bit SPECIAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic         dat_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] cfg_rd,
  output logic [W-1:0] dat_rd,
  output logic [W-1:0] pin_rd,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu,
  output logic         halt_pulse,
  output logic         idle_pulse,
  output logic         alt_phase,
  output logic         start_dly
);
  // bits that behave as ordinary pins (top two are repurposed on the special port)
  localparam logic [W-1:0] PIN_MASK = SPECIAL ? {2'b00, {(W-2){1'b1}}} : {W{1'b1}};

  logic [W-1:0] cfg_q, dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_we) cfg_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dat_q <= '0;
    else if (dat_we) dat_q <= wdata & PIN_MASK;
  end

  gpio_sync #(.W(W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pin_rd)
  );

  // joint decode of the configuration and data bits per pin
  always_comb begin
    pad_oe  = cfg_q & PIN_MASK;
    pad_out = cfg_q & dat_q;
    pad_pu  = ~cfg_q & dat_q;
  end

  assign cfg_rd = cfg_q;
  assign dat_rd = dat_q;

  generate
    if (SPECIAL) begin : g_special
      logic halt_q, idle_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          halt_q <= 1'b0;
          idle_q <= 1'b0;
        end else begin
          halt_q <= dat_we & wdata[W-1];
          idle_q <= dat_we & wdata[W-2];
        end
      end
      assign halt_pulse = halt_q;
      assign idle_pulse = idle_q;
      assign alt_phase  = cfg_q[W-2];
      assign start_dly  = cfg_q[W-1];

      // R8: a halt pulse only follows a data write with the top bit set
      p_halt_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halt_pulse |-> $past(dat_we && wdata[W-1]));
      // R8: an idle pulse only follows a data write with bit 6 set
      p_idle_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idle_pulse |-> $past(dat_we && wdata[W-2]));
    end else begin : g_plain
      assign halt_pulse = 1'b0;
      assign idle_pulse = 1'b0;
      assign alt_phase  = 1'b0;
      assign start_dly  = 1'b0;
    end
  endgenerate

  // R4: configuration only changes on a write
  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rd));
  // R4: data only changes on a write
  p_dat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_we |=> $stable(dat_rd));
endmodule

// File: rtl/gpio_outport.sv
module gpio_outport #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dat_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dat_rd
);
  logic [W-1:0] dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dat_q <= '1;
    else if (dat_we) dat_q <= wdata;
  end

  assign dat_rd = dat_q;

  // R11: leaving reset, the output port holds all ones
  p_preset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dat_rd == {W{1'b1}}));
endmodule

// File: rtl/gpio_portset.sv
module gpio_portset
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [DATA_W-1:0] a_pad_in,
  output logic [DATA_W-1:0] a_pad_oe,
  output logic [DATA_W-1:0] a_pad_out,
  output logic [DATA_W-1:0] a_pad_pu,
  input  logic [DATA_W-1:0] b_pad_in,
  output logic [DATA_W-1:0] b_pad_oe,
  output logic [DATA_W-1:0] b_pad_out,
  output logic [DATA_W-1:0] b_pad_pu,
  output logic [DATA_W-1:0] d_out,
  output logic              halt_req,
  output logic              idle_req,
  output logic              sk_alt_phase,
  output logic              clk_start_delay
);
  reg_sel_e sel;
  logic wr, rd;
  logic [DATA_W-1:0] a_cfg, a_dat, a_pin, b_cfg, b_dat, b_pin, d_dat, rd_mux;
  logic a_halt_nc, a_idle_nc, a_alt_nc, a_dly_nc;

  assign req_ready = 1'b1;
  assign wr = req_valid & req_write;
  assign rd = req_valid & ~req_write;

  always_comb begin
    unique case (req_addr)
      A_CFG:   sel = SEL_A_CFG;
      A_DAT:   sel = SEL_A_DAT;
      A_PIN:   sel = SEL_A_PIN;
      B_CFG:   sel = SEL_B_CFG;
      B_DAT:   sel = SEL_B_DAT;
      B_PIN:   sel = SEL_B_PIN;
      D_DAT:   sel = SEL_D_DAT;
      default: sel = SEL_NONE;
    endcase
  end

  gpio_port #(.W(DATA_W), .SPECIAL(1'b0)) u_port_a (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(wr && sel == SEL_A_CFG), .dat_we(wr && sel == SEL_A_DAT),
    .wdata(req_wdata), .pad_in(a_pad_in),
    .cfg_rd(a_cfg), .dat_rd(a_dat), .pin_rd(a_pin),
    .pad_oe(a_pad_oe), .pad_out(a_pad_out), .pad_pu(a_pad_pu),
    .halt_pulse(a_halt_nc), .idle_pulse(a_idle_nc),
    .alt_phase(a_alt_nc), .start_dly(a_dly_nc)
  );

  gpio_port #(.W(DATA_W), .SPECIAL(1'b1)) u_port_b (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(wr && sel == SEL_B_CFG), .dat_we(wr && sel == SEL_B_DAT),
    .wdata(req_wdata), .pad_in(b_pad_in),
    .cfg_rd(b_cfg), .dat_rd(b_dat), .pin_rd(b_pin),
    .pad_oe(b_pad_oe), .pad_out(b_pad_out), .pad_pu(b_pad_pu),
    .halt_pulse(halt_req), .idle_pulse(idle_req),
    .alt_phase(sk_alt_phase), .start_dly(clk_start_delay)
  );

  gpio_outport #(.W(DATA_W)) u_port_d (
    .clk(clk), .rst_n(rst_n),
    .dat_we(wr && sel == SEL_D_DAT),
    .wdata(req_wdata), .dat_rd(d_dat)
  );

  assign d_out = d_dat;

  always_comb begin
    unique case (sel)
      SEL_A_CFG: rd_mux = a_cfg;
      SEL_A_DAT: rd_mux = a_dat;
      SEL_A_PIN: rd_mux = a_pin;
      SEL_B_CFG: rd_mux = b_cfg;
      SEL_B_DAT: rd_mux = b_dat;
      SEL_B_PIN: rd_mux = b_pin;
      SEL_D_DAT: rd_mux = d_dat;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
    end
  end

  // R5: an answer only follows an accepted read
  p_rsp_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
  // R5: every accepted read is answered in the next cycle
  p_rsp_due_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
endmodule

// File: tb/gpio_portset_tb.sv
module gpio_portset_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic req_ready;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic rsp_valid;
  logic [7:0] rsp_rdata;
  logic [7:0] a_pad_in = '0, b_pad_in = '0;
  logic [7:0] a_pad_oe, a_pad_out, a_pad_pu, b_pad_oe, b_pad_out, b_pad_pu, d_out;
  logic halt_req, idle_req, sk_alt_phase, clk_start_delay;
  int n_checks = 0, n_fail = 0;

  always #4 clk = ~clk;

  gpio_portset dut_i (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid === 1'b1, {tag, " rsp_valid"}, rsp_valid, 1);
    check(rsp_rdata === exp, tag, rsp_rdata, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check(a_pad_oe === 8'h00 && a_pad_pu === 8'h00, "R1 port A idle", a_pad_oe | a_pad_pu, 0);
    check(b_pad_oe === 8'h00 && b_pad_pu === 8'h00, "R1 port B idle", b_pad_oe | b_pad_pu, 0);
    check({halt_req, idle_req, sk_alt_phase, clk_start_delay} === 4'h0, "R1 specials low",
          {halt_req, idle_req, sk_alt_phase, clk_start_delay}, 0);
    check(d_out === 8'hFF, "R11 preset", d_out, 8'hFF);
    check(req_ready === 1'b1, "R12 ready", req_ready, 1);
  endtask

  task automatic t_modes();
    bus_write(4'h0, 8'h0F);
    bus_write(4'h1, 8'h5A);
    check(a_pad_oe === 8'h0F, "R4 oe", a_pad_oe, 8'h0F);
    check((a_pad_out & 8'h0F) === 8'h0A, "R4 out", a_pad_out & 8'h0F, 8'h0A);
    check(a_pad_pu === 8'h50, "R3 pull-up", a_pad_pu, 8'h50);
    check(((a_pad_oe | a_pad_pu) & 8'hA0) === 8'h00, "R2 hi-z", (a_pad_oe | a_pad_pu) & 8'hA0, 0);
    bus_write(4'h0, 8'hFF);
    check(a_pad_out === 8'h5A && a_pad_pu === 8'h00, "R4 all drive", a_pad_out, 8'h5A);
  endtask

  task automatic t_readback();
    bus_read(4'h0, 8'hFF, "R5 A cfg");
    bus_read(4'h1, 8'h5A, "R5 A dat");
    bus_write(4'h4, 8'h12);
    bus_read(4'h4, 8'h12, "R5 B cfg");
  endtask

  task automatic t_pin_sync();
    @(negedge clk);
    a_pad_in = 8'h96; b_pad_in = 8'hC3;
    @(posedge clk); @(posedge clk);
    bus_read(4'h2, 8'h96, "R6 A pins");
    bus_read(4'h6, 8'hC3, "R6 B pins");
  endtask

  task automatic t_ignored();
    bus_write(4'h2, 8'h00);
    bus_write(4'hF, 8'h00);
    bus_write(4'h3, 8'h00);
    bus_read(4'h2, 8'h96, "R7 pin write ignored");
    bus_read(4'h0, 8'hFF, "R7 A cfg kept");
    bus_read(4'h1, 8'h5A, "R7 A dat kept");
    bus_read(4'hF, 8'h00, "R7 unmapped read");
    check(d_out === 8'hFF, "R7 D kept", d_out, 8'hFF);
  endtask

  task automatic t_pulses();
    bus_write(4'h4, 8'h00);
    bus_write(4'h5, 8'h80);
    check(halt_req === 1'b1 && idle_req === 1'b0, "R8 halt pulse", {halt_req, idle_req}, 2);
    @(negedge clk);
    check(halt_req === 1'b0, "R8 halt drops", halt_req, 0);
    bus_write(4'h5, 8'h41);
    check(idle_req === 1'b1 && halt_req === 1'b0, "R8 idle pulse", {halt_req, idle_req}, 1);
    check(b_pad_pu === 8'h01, "R9 bit6 not pulled", b_pad_pu, 8'h01);
    @(negedge clk);
    check(idle_req === 1'b0, "R8 idle drops", idle_req, 0);
    bus_read(4'h5, 8'h01, "R9 top data bits zero");
  endtask

  task automatic t_special_cfg();
    bus_write(4'h4, 8'hC0);
    check(sk_alt_phase === 1'b1 && clk_start_delay === 1'b1, "R10 outputs",
          {sk_alt_phase, clk_start_delay}, 3);
    bus_write(4'h5, 8'hFF);
    check(b_pad_oe === 8'h00, "R9 top pads not driven", b_pad_oe, 0);
    check(b_pad_pu === 8'h3F, "R9 top pads not pulled", b_pad_pu, 8'h3F);
    bus_read(4'h4, 8'hC0, "R10 readback");
    bus_read(4'h5, 8'h3F, "R9 data readback");
    bus_write(4'h4, 8'h40);
    check(sk_alt_phase === 1'b1 && clk_start_delay === 1'b0, "R10 phase only",
          {sk_alt_phase, clk_start_delay}, 2);
  endtask

  task automatic t_outport();
    bus_write(4'h8, 8'h3C);
    check(d_out === 8'h3C, "R11 drive", d_out, 8'h3C);
    bus_read(4'h8, 8'h3C, "R11 readback");
    do_reset();
    check(d_out === 8'hFF, "R11 re-preset", d_out, 8'hFF);
    check(a_pad_oe === 8'h00 && b_pad_pu === 8'h00, "R1 after re-reset", a_pad_oe | b_pad_pu, 0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'h1; req_wdata = 8'h11;
    @(negedge clk);
    req_addr = 4'h8; req_wdata = 8'h22;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check(req_ready === 1'b1, "R12 ready held", req_ready, 1);
    bus_read(4'h1, 8'h11, "R12 first taken");
    check(d_out === 8'h22, "R12 second taken", d_out, 8'h22);
  endtask

  initial begin
    t_reset();
    t_modes();
    t_readback();
    t_pin_sync();
    t_ignored();
    t_pulses();
    t_special_cfg();
    t_outport();
    t_back_to_back();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule